// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block hands out space in a shared packet RAM that is split into 256-byte pages. Software issues an 8-bit command word whose top three bits select one of eight operations. It can grab a run of pages for a transmit packet, give a packet back, remove entries from the receive queue with or without freeing their pages, put a packet on the transmit queue, clear the transmit queue, or wipe the whole allocator. A packet's number is the index of its first page. Every queue entry and result uses the same 7-bit packet-number space.

The receive engine asks for pages through its own request hook. A granted receive packet goes straight onto the receive queue. The transmit engine pops finished packets off the transmit queue through a dequeue strobe. Receive requests must leave a configurable number of pages untouched for transmit use. Host allocations may use those reserved pages.

Freeing a packet takes one clock per page. The block reports busy for that whole time and ignores any command issued while busy.

Top module: `pktbuf_alloc`

## Requirements
- R1: After reset, `alloc_result` is 0x80, `q_status` is 0x8080, `mem_info` is {NUM_PAGES, NUM_PAGES} (free count in bits 15:8, total in bits 7:0), and `busy`, `alloc_done` and `tx_empty_evt` are 0.
- R2: Command code 1 in bits 7:5 with count-1 in bits 4:0 requests N = count pages. The block grants the lowest-indexed run of N contiguous free pages. In the cycle after the command, `alloc_done` pulses for one cycle, `alloc_result` reads {0, start page}, and the free count has dropped by N.
- R3: If no contiguous run of N free pages exists, the command still pulses `alloc_done`, and `alloc_result` reads 0x80. The free count and both queues stay unchanged. This covers a fragmented pool whose free total would be large enough.
- R4: A receive request (`rx_alloc_req`, count-1 on `rx_alloc_len`) succeeds only if N ≤ free − `tx_rsv`, a contiguous run exists, and the receive queue is not full. The result is reported one cycle later on `rx_alloc_ack`, `rx_alloc_ok` and `rx_alloc_pkt`. A granted packet is appended to the receive queue. A host allocation of the same size can still succeed from the reserved pages.
- R5: `q_status` holds the receive empty flag in bit 15, the receive head in bits 14:8, the transmit empty flag in bit 7 and the transmit head in bits 6:0. A head field reads 0 when its queue is empty.
- R6: Code 3 removes the receive-queue head and leaves its pages allocated.
- R7: Code 4 removes the receive-queue head and frees its N pages. `busy` is high for exactly N cycles starting the cycle after the command, and the free count rises by one in each of those cycles.
- R8: Code 5 frees the packet whose number is on `pnr`, with the same busy timing as R7. A `pnr` that is not the first page of a live packet is ignored: `busy` stays low and the free count stays unchanged.
- R9: Code 6 appends the packet on `pnr` to the transmit queue if it is the start of a live packet, and otherwise does nothing. `tx_deq` removes the transmit head.
- R10: Code 7 empties the transmit queue and leaves the receive queue and the pages untouched.
- R11: Code 2 returns every page, both queues and `alloc_result` to the reset state. Code 0 changes nothing.
- R12: While `busy` is high, commands are ignored (no `alloc_done`, no state change) and receive requests are not served (no `rx_alloc_ack`).
- R13: `tx_empty_evt` pulses for one cycle in the cycle after the transmit queue goes from non-empty to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 8 | Opcode in bits 7:5, page count minus one in bits 4:0 |
| pnr | input | 7 | Packet number operand for free and transmit enqueue |
| tx_rsv | input | 5 | Pages held back from receive allocations |
| rx_alloc_req | input | 1 | Receive engine page request |
| rx_alloc_len | input | 5 | Receive request page count minus one |
| tx_deq | input | 1 | Transmit engine pops the transmit head |
| busy | output | 1 | Release in progress (read-back bit 0 of the command word) |
| alloc_done | output | 1 | One-cycle pulse when a host allocate completes |
| alloc_result | output | 8 | Bit 7 failure, bits 6:0 granted packet |
| rx_alloc_ack | output | 1 | One-cycle pulse answering a served receive request |
| rx_alloc_ok | output | 1 | Receive request granted |
| rx_alloc_pkt | output | 7 | Packet number granted to the receive engine |
| q_status | output | 16 | Queue heads and empty flags |
| mem_info | output | 16 | Free pages in bits 15:8, total pages in bits 7:0 |
| tx_empty_evt | output | 1 | Transmit queue became empty |

## Verification
A page bitmap that drifts from the true ownership shows up at once as a wrong start index on the next allocation, or as a free count in `mem_info` that differs from the expected running total in the cycle after the command. A wrong packet length shows up as a busy window of the wrong length, and as a free count that climbs by the wrong amount during a release. Queue corruption shows up in `q_status` one cycle after the push or pop that caused it, or at the latest when the head is popped and the next entry appears.

// File: rtl/pba_pkg.sv
package pba_pkg;

    localparam int PKT_W = 7;
    typedef logic [PKT_W-1:0] pkt_t;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ALLOC    = 3'd1,
        OP_RESET    = 3'd2,
        OP_RX_DROP  = 3'd3,
        OP_RX_FREE  = 3'd4,
        OP_FREE_PNR = 3'd5,
        OP_TX_ENQ   = 3'd6,
        OP_TX_RESET = 3'd7
    } op_e;

    localparam logic [7:0] RES_FAIL = 8'h80;

    function automatic logic [7:0] mk_result(input logic ok, input pkt_t p);
        return ok ? {1'b0, p} : RES_FAIL;
    endfunction

    function automatic logic [15:0] mk_qstat(input logic rx_e, input pkt_t rx_h,
                                             input logic tx_e, input pkt_t tx_h);
        return {rx_e, rx_e ? '0 : rx_h, tx_e, tx_e ? '0 : tx_h};
    endfunction

endpackage

// File: rtl/pba_pkt_fifo.sv
module pba_pkt_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 7,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_p, wr_p;
    logic [CW-1:0] cnt;
    logic          do_pop, do_push;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (int'(cnt) == DEPTH);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_p];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wr_p <= nxt(wr_p);
            if (do_pop)  rd_p <= nxt(rd_p);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_p] <= din;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= DEPTH); // R5

    AST_FIFO_POP_MOVES: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !do_push && !clr) |=> (cnt == $past(cnt) - 1'b1)); // R6

endmodule

// File: rtl/pba_page_map.sv
module pba_page_map #(
    parameter int NUM_PAGES = 32,
    parameter int MAX_RUN   = 32,
    localparam int IDX_W    = $clog2(NUM_PAGES),
    localparam int LEN_W    = $clog2(MAX_RUN + 1),
    localparam int CNT_W    = $clog2(NUM_PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic [LEN_W-1:0] req_len,
    output logic             fit_ok,
    output logic [IDX_W-1:0] fit_start,
    input  logic             commit,
    input  logic             rel_en,
    input  logic [IDX_W-1:0] rel_idx,
    input  pba_pkg::pkt_t    q_pkt,
    output logic             q_is_start,
    output logic [LEN_W-1:0] q_len,
    input  logic             unmark_en,
    output logic [CNT_W-1:0] free_cnt
);

    logic [NUM_PAGES-1:0] used;
    logic [NUM_PAGES-1:0] head;
    logic [LEN_W-1:0]     plen [NUM_PAGES];
    logic [NUM_PAGES-1:0] run_ok;
    logic                 q_in;
    logic [IDX_W-1:0]     q_idx;

    // one window checker per possible start page
    for (genvar s = 0; s < NUM_PAGES; s++) begin : g_fit
        logic ok;
        always_comb begin
            ok = (req_len != '0);
            for (int j = 0; j < MAX_RUN; j++) begin
                if (j < int'(req_len)) begin
                    if (s + j >= NUM_PAGES)          ok = 1'b0;
                    else if (used[(s + j) % NUM_PAGES]) ok = 1'b0;
                end
            end
        end
        assign run_ok[s] = ok;
    end

    always_comb begin
        fit_ok    = 1'b0;
        fit_start = '0;
        for (int s = NUM_PAGES - 1; s >= 0; s--) begin
            if (run_ok[s]) begin
                fit_ok    = 1'b1;
                fit_start = IDX_W'(s);
            end
        end
    end

    assign q_in       = int'(q_pkt) < NUM_PAGES;
    assign q_idx      = IDX_W'(q_pkt);
    assign q_is_start = q_in && head[q_idx];
    assign q_len      = plen[q_idx];
    assign free_cnt   = CNT_W'(NUM_PAGES) - CNT_W'($countones(used));

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            used <= '0;
            head <= '0;
        end else begin
            if (commit) begin
                for (int j = 0; j < MAX_RUN; j++) begin
                    if (j < int'(req_len) && int'(fit_start) + j < NUM_PAGES)
                        used[int'(fit_start) + j] <= 1'b1;
                end
                head[fit_start] <= 1'b1;
            end
            if (rel_en)              used[rel_idx] <= 1'b0;
            if (unmark_en && q_in)   head[q_idx]   <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (commit) plen[fit_start] <= req_len;
    end

    AST_COMMIT_FITS: assert property (@(posedge clk) disable iff (rst)
        commit |-> fit_ok); // R2

    AST_REL_USED: assert property (@(posedge clk) disable iff (rst)
        rel_en |-> used[rel_idx]); // R7

endmodule

// File: rtl/pktbuf_alloc.sv
module pktbuf_alloc
    import pba_pkg::*;
#(
    parameter int NUM_PAGES = 32,
    parameter int REQ_W     = 5,
    parameter int RSV_W     = 5,
    parameter int RXQ_DEPTH = 8,
    parameter int TXQ_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_word,
    input  logic [6:0]       pnr,
    input  logic [RSV_W-1:0] tx_rsv,
    input  logic             rx_alloc_req,
    input  logic [REQ_W-1:0] rx_alloc_len,
    input  logic             tx_deq,
    output logic             busy,
    output logic             alloc_done,
    output logic [7:0]       alloc_result,
    output logic             rx_alloc_ack,
    output logic             rx_alloc_ok,
    output logic [6:0]       rx_alloc_pkt,
    output logic [15:0]      q_status,
    output logic [15:0]      mem_info,
    output logic             tx_empty_evt
);

    localparam int MAX_RUN = 1 << REQ_W;
    localparam int IDX_W   = $clog2(NUM_PAGES);
    localparam int LEN_W   = $clog2(MAX_RUN + 1);
    localparam int CNT_W   = $clog2(NUM_PAGES + 1);

    op_e              op;
    logic             acc, host_alloc, rx_serve, rx_grant, commit;
    logic [LEN_W-1:0] host_len, rx_len, req_len, q_len;
    logic             fit_ok, q_is_start;
    logic [IDX_W-1:0] fit_start;
    logic [CNT_W-1:0] free_cnt;
    int               rx_avail;
    pkt_t             q_pkt;
    logic             free_go, clr_all;
    logic [IDX_W-1:0] fr_ptr;
    logic [LEN_W-1:0] fr_left;
    logic             rx_empty, rx_full, tx_empty, tx_full, txe_q;
    pkt_t             rx_head, tx_head;
    logic             rx_pop, tx_push, tx_clr;

    // command decode
    assign busy       = (fr_left != '0);
    assign acc        = cmd_valid && !busy;
    assign op         = op_e'(cmd_word[7:5]);
    assign host_alloc = acc && (op == OP_ALLOC);
    assign clr_all    = acc && (op == OP_RESET);
    assign host_len   = LEN_W'(cmd_word[REQ_W-1:0]) + LEN_W'(1);
    assign rx_len     = LEN_W'(rx_alloc_len) + LEN_W'(1);
    assign rx_serve   = rx_alloc_req && !busy && !cmd_valid;
    assign req_len    = host_alloc ? host_len : rx_len;

    // receive side may not dig into the reserved pages
    assign rx_avail = (int'(free_cnt) > int'(tx_rsv)) ? int'(free_cnt) - int'(tx_rsv) : 0;
    assign rx_grant = rx_serve && fit_ok && (int'(req_len) <= rx_avail) && !rx_full;
    assign commit   = (host_alloc && fit_ok) || rx_grant;

    // operand packet: receive head for code 4, otherwise the pnr input
    assign q_pkt   = (op == OP_RX_FREE) ? rx_head : pnr;
    assign free_go = acc && q_is_start &&
                     (((op == OP_RX_FREE) && !rx_empty) || (op == OP_FREE_PNR));
    assign rx_pop  = acc && ((op == OP_RX_DROP) || (op == OP_RX_FREE));
    assign tx_push = acc && (op == OP_TX_ENQ) && q_is_start;
    assign tx_clr  = clr_all || (acc && (op == OP_TX_RESET));

    pba_page_map #(
        .NUM_PAGES (NUM_PAGES),
        .MAX_RUN   (MAX_RUN)
    ) u_map (
        .clk        (clk),
        .rst        (rst),
        .clr_all    (clr_all),
        .req_len    (req_len),
        .fit_ok     (fit_ok),
        .fit_start  (fit_start),
        .commit     (commit),
        .rel_en     (busy),
        .rel_idx    (fr_ptr),
        .q_pkt      (q_pkt),
        .q_is_start (q_is_start),
        .q_len      (q_len),
        .unmark_en  (free_go),
        .free_cnt   (free_cnt)
    );

    pba_pkt_fifo #(.DEPTH(RXQ_DEPTH), .W(PKT_W)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_all),
        .push  (rx_grant),
        .pop   (rx_pop),
        .din   (PKT_W'(fit_start)),
        .dout  (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    pba_pkt_fifo #(.DEPTH(TXQ_DEPTH), .W(PKT_W)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .clr   (tx_clr),
        .push  (tx_push),
        .pop   (tx_deq),
        .din   (pnr),
        .dout  (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    // release walker: one page per cycle
    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            fr_ptr  <= '0;
            fr_left <= '0;
        end else if (free_go) begin
            fr_ptr  <= IDX_W'(q_pkt);
            fr_left <= q_len;
        end else if (busy) begin
            fr_ptr  <= fr_ptr + 1'b1;
            fr_left <= fr_left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_done   <= 1'b0;
            alloc_result <= RES_FAIL;
            rx_alloc_ack <= 1'b0;
            rx_alloc_ok  <= 1'b0;
            rx_alloc_pkt <= '0;
            txe_q        <= 1'b1;
        end else begin
            alloc_done   <= host_alloc;
            rx_alloc_ack <= rx_serve;
            rx_alloc_ok  <= rx_grant;
            txe_q        <= tx_empty;
            if (host_alloc) alloc_result <= mk_result(fit_ok, PKT_W'(fit_start));
            if (clr_all)    alloc_result <= RES_FAIL;
            if (rx_grant)   rx_alloc_pkt <= PKT_W'(fit_start);
        end
    end

    assign tx_empty_evt = tx_empty && !txe_q;
    assign q_status     = mk_qstat(rx_empty, rx_head, tx_empty, tx_head);
    assign mem_info     = {8'(free_cnt), 8'(NUM_PAGES)};

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!alloc_done && !rx_alloc_ack)); // R12

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
        busy |=> (free_cnt == $past(free_cnt) + 1'b1)); // R7

    AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (alloc_done && alloc_result[7]) |-> (free_cnt == $past(free_cnt))); // R3

    AST_RSV_KEPT: assert property (@(posedge clk) disable iff (rst)
        (rx_alloc_ack && rx_alloc_ok) |-> (int'(free_cnt) >= int'($past(tx_rsv)))); // R4

    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_empty_evt |=> !tx_empty_evt); // R13

endmodule

// File: tb/tb_pktbuf_alloc.sv
module tb_pktbuf_alloc;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [7:0]  cmd_word;
    logic [6:0]  pnr;
    logic [4:0]  tx_rsv;
    logic        rx_alloc_req;
    logic [4:0]  rx_alloc_len;
    logic        tx_deq;
    logic        busy, alloc_done, rx_alloc_ack, rx_alloc_ok, tx_empty_evt;
    logic [7:0]  alloc_result;
    logic [6:0]  rx_alloc_pkt;
    logic [15:0] q_status, mem_info;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pktbuf_alloc dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .pnr(pnr), .tx_rsv(tx_rsv), .rx_alloc_req(rx_alloc_req),
        .rx_alloc_len(rx_alloc_len), .tx_deq(tx_deq), .busy(busy),
        .alloc_done(alloc_done), .alloc_result(alloc_result),
        .rx_alloc_ack(rx_alloc_ack), .rx_alloc_ok(rx_alloc_ok),
        .rx_alloc_pkt(rx_alloc_pkt), .q_status(q_status), .mem_info(mem_info),
        .tx_empty_evt(tx_empty_evt)
    );

    // {cmd, pnr, expected result, expected free pages}
    localparam logic [31:0] VEC [12] = '{
        {8'h23, 8'h00, 8'h00, 8'd28},
        {8'h20, 8'h00, 8'h04, 8'd27},
        {8'h27, 8'h00, 8'h05, 8'd19},
        {8'h27, 8'h00, 8'h0D, 8'd11},
        {8'h27, 8'h00, 8'h15, 8'd3},
        {8'h23, 8'h00, 8'h80, 8'd3},
        {8'h22, 8'h00, 8'h1D, 8'd0},
        {8'h20, 8'h00, 8'h80, 8'd0},
        {8'hA0, 8'h04, 8'h00, 8'd1},
        {8'h21, 8'h00, 8'h80, 8'd1},
        {8'hA0, 8'h00, 8'h00, 8'd5},
        {8'h24, 8'h00, 8'h00, 8'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [7:0] c, input logic [6:0] p);
        cmd_valid = 1'b1;
        cmd_word  = c;
        pnr       = p;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_rx(input logic [4:0] lm1);
        rx_alloc_req = 1'b1;
        rx_alloc_len = lm1;
        @(negedge clk);
        rx_alloc_req = 1'b0;
    endtask

    task automatic do_deq();
        tx_deq = 1'b1;
        @(negedge clk);
        tx_deq = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        finish_run();
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_word = '0; pnr = '0; tx_rsv = '0;
        rx_alloc_req = 1'b0; rx_alloc_len = '0; tx_deq = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 result",   {24'd0, alloc_result}, 32'h80);
        chk("R1 q_status", {16'd0, q_status}, 32'h8080);
        chk("R1 mem_info", {16'd0, mem_info}, 32'h2020);
        chk("R1 busy",     {31'd0, busy}, 32'd0);
        chk("R1 done",     {31'd0, alloc_done}, 32'd0);

        // R2 R3 R8 vector walk: first fit, exhaustion, fragmentation
        for (int i = 0; i < 12; i++) begin
            logic [7:0] c;
            c = VEC[i][31:24];
            do_cmd(c, VEC[i][22:16]);
            if (c[7:5] == 3'd1) begin
                chk("R2 done pulse", {31'd0, alloc_done}, 32'd1);
                chk(VEC[i][15] ? "R3 fail result" : "R2 grant result",
                    {24'd0, alloc_result}, {24'd0, VEC[i][15:8]});
            end
            wait_idle();
            chk("R2 R3 R8 free count", {24'd0, mem_info[15:8]}, {24'd0, VEC[i][7:0]});
        end
        @(negedge clk);
        chk("R2 done one cycle", {31'd0, alloc_done}, 32'd0);

        // R11 whole reset command, and code 0
        do_cmd(8'h40, 7'd0);
        chk("R11 mem_info", {16'd0, mem_info}, 32'h2020);
        chk("R11 result",   {24'd0, alloc_result}, 32'h80);
        chk("R11 q_status", {16'd0, q_status}, 32'h8080);
        do_cmd(8'h00, 7'd0);
        chk("R11 nop", {16'd0, mem_info}, 32'h2020);

        // R4 receive allocation against a reserve of 4
        tx_rsv = 5'd4;
        do_rx(5'd7);
        chk("R4 ack", {30'd0, rx_alloc_ack, rx_alloc_ok}, 32'd3);
        chk("R4 pkt", {25'd0, rx_alloc_pkt}, 32'd0);
        chk("R5 q after rx", {16'd0, q_status}, 32'h0080);
        do_rx(5'd7);
        chk("R4 pkt2", {25'd0, rx_alloc_pkt}, 32'd8);
        do_rx(5'd7);
        chk("R4 pkt3", {25'd0, rx_alloc_pkt}, 32'd16);
        do_rx(5'd7);
        chk("R4 reserve refuses", {30'd0, rx_alloc_ack, rx_alloc_ok}, 32'd2);
        chk("R4 free kept", {24'd0, mem_info[15:8]}, 32'd8);
        do_cmd(8'h27, 7'd0);
        chk("R4 host uses reserve", {24'd0, alloc_result}, 32'h18);
        chk("R4 free zero", {24'd0, mem_info[15:8]}, 32'd0);

        // R6 drop keeps pages
        do_cmd(8'h60, 7'd0);
        chk("R6 rx head", {16'd0, q_status}, 32'h0880);
        chk("R6 pages kept", {24'd0, mem_info[15:8]}, 32'd0);

        // R7 drop and free, with R12 ignored command during busy
        do_cmd(8'h80, 7'd0);
        chk("R7 busy start", {31'd0, busy}, 32'd1);
        chk("R7 rx head", {16'd0, q_status}, 32'h1080);
        do_cmd(8'h20, 7'd0);
        chk("R12 ignored alloc", {31'd0, alloc_done}, 32'd0);
        rx_alloc_req = 1'b1; rx_alloc_len = 5'd0;
        repeat (6) @(negedge clk);
        rx_alloc_req = 1'b0;
        chk("R12 rx not served", {31'd0, rx_alloc_ack}, 32'd0);
        chk("R7 busy last", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R7 busy end", {31'd0, busy}, 32'd0);
        chk("R7 freed 8", {24'd0, mem_info[15:8]}, 32'd8);

        // R8 free by number, invalid number ignored
        do_cmd(8'hA0, 7'd24);
        wait_idle();
        chk("R8 freed", {24'd0, mem_info[15:8]}, 32'd16);
        do_cmd(8'hA0, 7'd3);
        chk("R8 invalid busy", {31'd0, busy}, 32'd0);
        chk("R8 invalid free", {24'd0, mem_info[15:8]}, 32'd16);

        // R9 transmit enqueue and dequeue, R13 empty event
        do_cmd(8'hC0, 7'd0);
        chk("R9 tx head", {16'd0, q_status}, 32'h1000);
        do_cmd(8'hC0, 7'd16);
        do_cmd(8'hC0, 7'd5);
        do_deq();
        chk("R9 tx next", {16'd0, q_status}, 32'h1010);
        chk("R13 no evt", {31'd0, tx_empty_evt}, 32'd0);
        do_deq();
        chk("R9 invalid not queued", {16'd0, q_status}, 32'h1080);
        chk("R13 evt", {31'd0, tx_empty_evt}, 32'd1);
        @(negedge clk);
        chk("R13 evt one cycle", {31'd0, tx_empty_evt}, 32'd0);

        // R10 transmit queue reset only
        do_cmd(8'hC0, 7'd0);
        do_cmd(8'hE0, 7'd0);
        chk("R10 q_status", {16'd0, q_status}, 32'h1080);
        chk("R10 pages", {24'd0, mem_info[15:8]}, 32'd16);

        finish_run();
    end

endmodule